// File: doc/BRIEF.md
# Pin Level-Sense Latch and Detect

This block watches the input levels of a port of up to 32 pins and turns them into detect signals. Each pin carries a 2-bit sense code that asks for a high level, a low level, or nothing. When the synchronized level of a pin matches its code, that pin raises its own detect flag. A pin that has just detected must then sit at its non-sensing level for a set number of clock cycles before it can detect again.

A rising edge on any pin's detect sets that pin's bit in a sticky latch word. Software clears bits by writing ones to them. A clear is refused for a pin whose detect is still high, so no event is lost. A latched detect summarises the latch word. After a clear write that leaves bits set, the latched detect drops for one cycle and then rises again, so that an edge-triggered consumer sees a new event. A single mode input chooses what drives the port-level detect: the live OR of all pin detects, or the latched detect.

Top module: `pin_sense_latch`

## Requirements
- R1: Sense code 2 (binary 10) gives a detect while the pin is 1. Code 3 (binary 11) gives a detect while the pin is 0. Codes 0 and 1 never give a detect. Pin n's code sits in bits [2n+1:2n] of `sense_cfg`. An armed pin's detect reaches `port_det` in mode 0 in the same cycle, with no clock edge in between.
- R2: When a code is written that already matches the pin level, and the pin is armed, the detect is high in that same cycle.
- R3: After a pin's detect falls, the pin must see REARM consecutive clock edges (3 by default) with no match before a match produces a detect again. A match that comes earlier gives no detect and restarts the count.
- R4: A rising detect on pin n sets bit n of `latch_q` at the next clock edge.
- R5: When `clr_stb` is high, each bit of `latch_q` whose `clr_mask` bit is 1 clears at the next edge. Bits whose mask is 0 are left as they are.
- R6: A latch bit is not cleared by a clear write while that pin's detect is high.
- R7: A falling detect leaves the latch bit unchanged.
- R8: Outside the cycle after a clear write, `lat_det` is 1 exactly when `latch_q` is nonzero. It changes on the same edge as `latch_q`.
- R9: In the cycle after any clear write, `lat_det` is 0. If bits remain set, it returns to 1 one cycle later.
- R10: With `mode_lat` at 0, `port_det` is the OR of the pin detects. With `mode_lat` at 1, it equals `lat_det`.
- R11: Reset clears `latch_q` and `lat_det` and leaves every pin armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| sense_cfg | input | 2*NPINS | Per-pin sense codes, two bits per pin |
| clr_stb | input | 1 | Latch clear write strobe |
| clr_mask | input | NPINS | Latch clear data; 1 clears that bit |
| mode_lat | input | 1 | Port detect source: 0 live OR, 1 latched |
| latch_q | output | NPINS | Latch word read value |
| lat_det | output | 1 | Latched detect |
| port_det | output | 1 | Port detect |

## Verification
The assertions assume that `pin_lvl`, `sense_cfg`, `clr_stb` and `clr_mask` are already synchronous to `clk` and stable around each rising edge. They also assume REARM is at least 2, so that a falling detect cannot come straight back. The bench changes every input only at the falling edge. It checks the combinational port detect a short time later and the registered outputs just after the following rising edge, so no input ever moves near an edge. Sense codes 1 and 0 are both driven on pins whose levels toggle, which shows that neither code leads to a detect.

// File: rtl/psl_pkg.sv
package psl_pkg;

    typedef enum logic [1:0] {
        SNS_OFF  = 2'd0,
        SNS_RSV  = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    function automatic logic sense_hit(input sense_e code, input logic lvl);
        case (code)
            SNS_HIGH: sense_hit = lvl;
            SNS_LOW:  sense_hit = ~lvl;
            default:  sense_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/psl_pin_cell.sv
module psl_pin_cell
    import psl_pkg::*;
#(
    parameter int REARM = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [1:0] code,
    output logic       det,
    output logic       det_prev
);
    localparam int CW = $clog2(REARM + 1);
    localparam logic [CW-1:0] QMAX = CW'(REARM);

    typedef struct packed {
        logic          live;
        logic [CW-1:0] quiet;
    } cell_t;

    cell_t st_d, st_q;
    logic  match;
    logic  armed;

    always_comb begin
        match = sense_hit(sense_e'(code), lvl);
        armed = st_q.live | (st_q.quiet == QMAX);
        det   = match & armed;
        st_d.live = det;
        if (match)
            st_d.quiet = '0;
        else if (st_q.quiet == QMAX)
            st_d.quiet = st_q.quiet;
        else
            st_d.quiet = st_q.quiet + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.live  <= 1'b0;
            st_q.quiet <= QMAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_prev = st_q.live;

    // R3: a detect that has just fallen cannot reassert on the next cycle
    p_rearm_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (det_prev && !det) |=> !det);

endmodule

// File: rtl/psl_latch_bank.sv
module psl_latch_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] det,
    input  logic [NPINS-1:0] det_prev,
    input  logic             clr_stb,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] latch_q,
    output logic             lat_det
);
    typedef struct packed {
        logic [NPINS-1:0] bits;
        logic             ld;
    } bank_t;

    bank_t            bk_d, bk_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] clr_ok;

    always_comb begin
        rise    = det & ~det_prev;
        clr_ok  = clr_stb ? (clr_mask & ~det) : '0;
        bk_d.bits = (bk_q.bits & ~clr_ok) | rise;
        bk_d.ld   = (|bk_d.bits) & ~clr_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign latch_q = bk_q.bits;
    assign lat_det = bk_q.ld;

    // R4: every rising pin detect is recorded at the next edge
    p_set_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(det & ~det_prev)) == $past(det & ~det_prev)));

    // R6: set bits whose pin still detects survive any clear
    p_clr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & $past(latch_q & det)) == $past(latch_q & det)));

    // R9: latched detect is low in the cycle after a clear write
    p_clear_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !lat_det);

    // R8: outside the gap, latched detect mirrors a nonzero latch word
    p_ld_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_stb) |-> (lat_det == (|latch_q)));

endmodule

// File: rtl/pin_sense_latch.sv
module pin_sense_latch
    import psl_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int REARM = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_lvl,
    input  logic [2*NPINS-1:0] sense_cfg,
    input  logic               clr_stb,
    input  logic [NPINS-1:0]   clr_mask,
    input  logic               mode_lat,
    output logic [NPINS-1:0]   latch_q,
    output logic               lat_det,
    output logic               port_det
);
    logic [NPINS-1:0] det;
    logic [NPINS-1:0] det_prev;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        psl_pin_cell #(.REARM(REARM)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_lvl[g]),
            .code     (sense_cfg[2*g +: 2]),
            .det      (det[g]),
            .det_prev (det_prev[g])
        );
    end

    psl_latch_bank #(.NPINS(NPINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .det      (det),
        .det_prev (det_prev),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .latch_q  (latch_q),
        .lat_det  (lat_det)
    );

    always_comb begin
        port_det = mode_lat ? lat_det : (|det);
    end

    // R10: latched mode forwards the latched detect
    p_mode_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_lat |-> (port_det == lat_det));

    // R10: live mode reports any pin detect
    p_mode_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_lat && (|det)) |-> port_det);

endmodule

// File: tb/pin_sense_latch_test.sv
`timescale 1ns/1ps
module pin_sense_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic [63:0] sense_cfg = '0;
    logic        clr_stb = 1'b0;
    logic [31:0] clr_mask = '0;
    logic        mode_lat = 1'b0;
    logic [31:0] latch_q;
    logic        lat_det;
    logic        port_det;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pin_sense_latch uut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sense_cfg(sense_cfg),
        .clr_stb(clr_stb), .clr_mask(clr_mask), .mode_lat(mode_lat),
        .latch_q(latch_q), .lat_det(lat_det), .port_det(port_det)
    );

    // row: pins[23:20] sense[19:12] clr[11] mask[10:7] mode[6]
    //      exp_port[5] exp_latch[4:1] exp_ld[0]
    localparam int NROW = 20;
    localparam logic [23:0] TBL [NROW] = '{
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0}, // idle
        {4'b0011, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b1}, // R1 high
        {4'b0000, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0011, 1'b1}, // R1 low, R7
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b1, 1'b1, 4'b0011, 1'b1}, // R10
        {4'b0010, 8'h4E, 1'b1, 4'b0001, 1'b1, 1'b1, 4'b0010, 1'b0}, // R5
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b1, 1'b0, 4'b0010, 1'b1}, // R9
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b1, 1'b1, 4'b0010, 1'b1},
        {4'b0001, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0011, 1'b1}, // R4
        {4'b0001, 8'h4E, 1'b1, 4'b0011, 1'b0, 1'b1, 4'b0011, 1'b0}, // R6
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0011, 1'b1},
        {4'b0010, 8'h4E, 1'b1, 4'b0011, 1'b0, 1'b0, 4'b0000, 1'b0}, // R5
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0}, // R8
        {4'b0011, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b1},
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1},
        {4'b0011, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1}, // R3 early
        {4'b1110, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1}, // R1 off codes
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1},
        {4'b0010, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1},
        {4'b0011, 8'h4E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b1}, // R3 rearmed
        {4'b0110, 8'h6E, 1'b0, 4'b0000, 1'b0, 1'b1, 4'b0101, 1'b1}  // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 latch at reset", latch_q, 32'h0);
        chk("R11 lat_det at reset", {31'b0, lat_det}, 32'h0);
        rst_n = 1'b1;

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            pin_lvl   = {28'b0, TBL[r][23:20]};
            sense_cfg = {56'b0, TBL[r][19:12]};
            clr_stb   = TBL[r][11];
            clr_mask  = {28'b0, TBL[r][10:7]};
            mode_lat  = TBL[r][6];
            #1;
            chk($sformatf("R1/R10 port_det row %0d", r), {31'b0, port_det}, {31'b0, TBL[r][5]});
            @(posedge clk);
            #1;
            chk($sformatf("R4/R5 latch_q row %0d", r), latch_q, {28'b0, TBL[r][4:1]});
            chk($sformatf("R8/R9 lat_det row %0d", r), {31'b0, lat_det}, {31'b0, TBL[r][0]});
        end

        // R11: reset in the middle of a run empties a nonzero latch
        @(negedge clk);
        clr_stb = 1'b0; mode_lat = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R11 latch after mid reset", latch_q, 32'h0);
        chk("R11 lat_det after mid reset", {31'b0, lat_det}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        sense_cfg = 64'hC000_0000_0000_0000;
        pin_lvl = 32'hFFFF_FFFF;

        // R1: top pin, low-level sense
        @(negedge clk);
        pin_lvl = 32'h7FFF_FFFF;
        #1;
        chk("R1 pin31 low sense", {31'b0, port_det}, 32'h1);
        @(posedge clk); #1;
        chk("R4 pin31 latched", latch_q, 32'h8000_0000);

        // R6: clear refused while detect still high
        @(negedge clk);
        clr_stb = 1'b1; clr_mask = 32'h8000_0000;
        @(posedge clk); #1;
        chk("R6 clear blocked", latch_q, 32'h8000_0000);
        chk("R9 gap after clear", {31'b0, lat_det}, 32'h0);
        @(negedge clk);
        clr_stb = 1'b0; clr_mask = '0;
        @(posedge clk); #1;
        chk("R9 lat_det reasserts", {31'b0, lat_det}, 32'h1);

        // R5: clear succeeds once detect is gone
        @(negedge clk);
        pin_lvl = 32'hFFFF_FFFF;
        clr_stb = 1'b1; clr_mask = 32'h8000_0000;
        @(posedge clk); #1;
        chk("R5 clear after release", latch_q, 32'h0);
        @(negedge clk);
        clr_stb = 1'b0; clr_mask = '0;
        mode_lat = 1'b1;
        #1;
        chk("R10 latched mode low", {31'b0, port_det}, 32'h0);
        @(posedge clk); #1;
        chk("R8 lat_det stays low when empty", {31'b0, lat_det}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule